// File: doc/BRIEF.md
# Byte-Lane Controller for a 32-bit Asynchronous Static RAM

This block sits between a clocked host and an external asynchronous static RAM of 128K words by 32 bits. The memory is built from four byte-wide devices, and each device has its own active-low select. The host issues one request at a time: a word address, a read/write flag, write data and a four-bit byte mask. The controller then sequences the memory strobes and returns a single-cycle completion pulse. For reads, it also returns the captured word.

Each bit of the byte mask maps straight onto one device select. Partial-word reads and writes therefore need nothing more than a select pattern. Every strobe phase has a minimum length set at elaboration from the clock period and nanosecond parameters, rounded up to whole cycles. Write data is driven only while the output enable is inactive. After every read there is a quiet window with all selects high before the next access starts.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held, all four selects, write enable and output enable are high, data drive is off, done is low and ready is high.
- R2: Mask bit i drives select i low for the access, and select i owns data bits 8i+7 to 8i (bit 0 to bits 7:0, bit 3 to bits 31:24); a zero mask bit leaves its select high.
- R3: A write changes only the bytes whose mask bit is set; a full-mask read returns the word last written.
- R4: A write spends one cycle with its selects low, write enable high and data driven, then holds write enable low for PULSE cycles. PULSE is the largest of the rounded-up counts for pulse width, data setup, address-to-end and select-to-end, and data is driven throughout.
- R5: Address, select pattern and write data do not change while write enable is low, nor in the cycle in which it returns high.
- R6: A read holds its selects and output enable low, with write enable high, for ACC cycles, where ACC is the larger of the rounded-up address-access and output-enable-access counts. The data pins are sampled at the clock edge that ends this phase.
- R7: Read bytes whose mask bit is clear are returned as zero, whatever the data pins carry.
- R8: Write data is never driven while output enable is low, and write enable is never low while output enable is low.
- R9: After a read phase ends, all selects stay high and data drive stays off for at least TURN+1 cycles before the next access. TURN is the rounded-up bus release time, at least 1.
- R10: Done is a one-cycle pulse. It rises 1+PULSE+REC clock edges after the accepting edge for a write, and ACC+TURN edges after it for a read. REC is the larger of 1 and the write-cycle count minus 1+PULSE.
- R11: Ready is high only when no access is in progress, and a request presented in the cycle of done is accepted at once.
- R12: For a write with a non-empty mask, the selects stay low for exactly 1+PULSE+REC cycles, which is no fewer than the rounded-up write-cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Request strobe, taken when ready is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Word address |
| host_wdata | input | 32 | Write data |
| host_be | input | 4 | Byte mask, bit i for bits 8i+7:8i |
| host_ready | output | 1 | Controller idle, request will be taken |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Captured read word, unselected bytes zero |
| mem_addr | output | 17 | Memory address |
| mem_cs_n | output | 4 | Active-low device selects |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 32 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 32 | Data from the memory |

## Verification
Two things can fall in the same cycle: the done pulse of one access and the acceptance of the next request, including the case of a read followed at once by a write. The bench provokes this on every access by presenting the next request in the done cycle. A memory model on the strobes then judges three things. It checks that the quiet gap after the read is at least TURN+1 cycles. It checks that no write data is driven while output enable is low. It checks that the new write's phase widths are unchanged. Read-back of every pair of write and read masks, checked against a bench shadow copy, judges the result.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WREC,
        ST_RACC,
        ST_TURN
    } phase_e;

    // Rounds a nanosecond figure up to whole clock cycles.
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_lane_sel.sv
module sram_lane_sel #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic [LANES-1:0]        launch_be,
    output logic [LANES-1:0]        launch_cs_n,
    input  logic [LANES-1:0]        held_be,
    input  logic [LANES*LANE_W-1:0] raw_rd,
    output logic [LANES*LANE_W-1:0] rd_masked
);

    // One select per byte lane; lanes outside the mask read as zero.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign launch_cs_n[g]                  = ~launch_be[g];
        assign rd_masked[g*LANE_W +: LANE_W]   = held_be[g] ? raw_rd[g*LANE_W +: LANE_W]
                                                            : {LANE_W{1'b0}};
    end

endmodule

// File: rtl/sram_lane_fsm.sv
module sram_lane_fsm
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int LANES     = 4,
    parameter int LANE_W    = 8,
    parameter int PULSE_CYC = 1,
    parameter int REC_CYC   = 1,
    parameter int ACC_CYC   = 1,
    parameter int TURN_CYC  = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req,
    input  logic                     req_we,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [LANES*LANE_W-1:0]  req_wdata,
    input  logic [LANES-1:0]         req_be,
    input  logic [LANES-1:0]         lane_cs_n,
    input  logic [LANES*LANE_W-1:0]  rd_masked,
    output logic [LANES-1:0]         held_be,
    output logic                     ready,
    output logic                     done,
    output logic [LANES*LANE_W-1:0]  rdata,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [LANES-1:0]         mem_cs_n,
    output logic                     mem_we_n,
    output logic                     mem_oe_n,
    output logic [LANES*LANE_W-1:0]  mem_dq_out,
    output logic                     mem_dq_oe
);

    localparam int DATA_W = LANES * LANE_W;
    localparam int MAXC   = max2(max2(PULSE_CYC, REC_CYC), max2(ACC_CYC, TURN_CYC));
    localparam int CW     = (MAXC < 2) ? 1 : $clog2(MAXC);

    localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] REC_LAST   = CW'(REC_CYC - 1);
    localparam logic [CW-1:0] ACC_LAST   = CW'(ACC_CYC - 1);
    localparam logic [CW-1:0] TURN_LAST  = CW'(TURN_CYC - 1);

    typedef struct packed {
        phase_e              ph;
        logic [CW-1:0]       cnt;
        logic [ADDR_W-1:0]   addr;
        logic [LANES-1:0]    be;
        logic [LANES-1:0]    cs_n;
        logic                we_n;
        logic                oe_n;
        logic [DATA_W-1:0]   wdat;
        logic                dq_oe;
        logic [DATA_W-1:0]   rdat;
        logic                done;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        ph:    ST_IDLE,
        cnt:   '0,
        addr:  '0,
        be:    '0,
        cs_n:  '1,
        we_n:  1'b1,
        oe_n:  1'b1,
        wdat:  '0,
        dq_oe: 1'b0,
        rdat:  '0,
        done:  1'b0
    };

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.ph)
            ST_IDLE: begin
                if (req) begin
                    ctl_d.addr = req_addr;
                    ctl_d.be   = req_be;
                    ctl_d.cs_n = lane_cs_n;
                    ctl_d.cnt  = '0;
                    if (req_we) begin
                        ctl_d.ph    = ST_WSETUP;
                        ctl_d.wdat  = req_wdata;
                        ctl_d.dq_oe = 1'b1;
                    end else begin
                        ctl_d.ph   = ST_RACC;
                        ctl_d.oe_n = 1'b0;
                    end
                end
            end
            ST_WSETUP: begin
                ctl_d.ph   = ST_WPULSE;
                ctl_d.we_n = 1'b0;
                ctl_d.cnt  = '0;
            end
            ST_WPULSE: begin
                if (ctl_q.cnt == PULSE_LAST) begin
                    ctl_d.ph   = ST_WREC;
                    ctl_d.we_n = 1'b1;
                    ctl_d.cnt  = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_WREC: begin
                if (ctl_q.cnt == REC_LAST) begin
                    ctl_d.ph    = ST_IDLE;
                    ctl_d.cs_n  = '1;
                    ctl_d.dq_oe = 1'b0;
                    ctl_d.done  = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_RACC: begin
                if (ctl_q.cnt == ACC_LAST) begin
                    ctl_d.ph   = ST_TURN;
                    ctl_d.rdat = rd_masked;
                    ctl_d.cs_n = '1;
                    ctl_d.oe_n = 1'b1;
                    ctl_d.cnt  = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_TURN: begin
                if (ctl_q.cnt == TURN_LAST) begin
                    ctl_d.ph   = ST_IDLE;
                    ctl_d.done = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            default: ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign held_be    = ctl_q.be;
    assign ready      = (ctl_q.ph == ST_IDLE);
    assign done       = ctl_q.done;
    assign rdata      = ctl_q.rdat;
    assign mem_addr   = ctl_q.addr;
    assign mem_cs_n   = ctl_q.cs_n;
    assign mem_we_n   = ctl_q.we_n;
    assign mem_oe_n   = ctl_q.oe_n;
    assign mem_dq_out = ctl_q.wdat;
    assign mem_dq_oe  = ctl_q.dq_oe;

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W        = 17,
    parameter int LANES         = 4,
    parameter int LANE_W        = 8,
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_WC_NS       = 20,
    parameter int T_WP_NS       = 15,
    parameter int T_SCS_NS      = 15,
    parameter int T_AW_NS       = 15,
    parameter int T_DS_NS       = 10,
    parameter int T_AA_NS       = 20,
    parameter int T_DOE_NS      = 8,
    parameter int T_HZ_NS       = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_req,
    input  logic                     host_we,
    input  logic [ADDR_W-1:0]        host_addr,
    input  logic [LANES*LANE_W-1:0]  host_wdata,
    input  logic [LANES-1:0]         host_be,
    output logic                     host_ready,
    output logic                     host_done,
    output logic [LANES*LANE_W-1:0]  host_rdata,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [LANES-1:0]         mem_cs_n,
    output logic                     mem_we_n,
    output logic                     mem_oe_n,
    output logic [LANES*LANE_W-1:0]  mem_dq_out,
    output logic                     mem_dq_oe,
    input  logic [LANES*LANE_W-1:0]  mem_dq_in
);

    localparam int DATA_W    = LANES * LANE_W;
    localparam int PULSE_CYC = max2(1, max2(max2(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                                 ns_to_cyc(T_DS_NS, CLK_PERIOD_NS)),
                                            max2(ns_to_cyc(T_AW_NS, CLK_PERIOD_NS),
                                                 ns_to_cyc(T_SCS_NS, CLK_PERIOD_NS))));
    localparam int REC_CYC   = max2(1, ns_to_cyc(T_WC_NS, CLK_PERIOD_NS) - 1 - PULSE_CYC);
    localparam int ACC_CYC   = max2(1, max2(ns_to_cyc(T_AA_NS, CLK_PERIOD_NS),
                                            ns_to_cyc(T_DOE_NS, CLK_PERIOD_NS)));
    localparam int TURN_CYC  = max2(1, ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS));

    logic [LANES-1:0]  lane_cs_n;
    logic [LANES-1:0]  held_be;
    logic [DATA_W-1:0] rd_masked;

    sram_lane_sel #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_sel (
        .launch_be   (host_be),
        .launch_cs_n (lane_cs_n),
        .held_be     (held_be),
        .raw_rd      (mem_dq_in),
        .rd_masked   (rd_masked)
    );

    sram_lane_fsm #(
        .ADDR_W    (ADDR_W),
        .LANES     (LANES),
        .LANE_W    (LANE_W),
        .PULSE_CYC (PULSE_CYC),
        .REC_CYC   (REC_CYC),
        .ACC_CYC   (ACC_CYC),
        .TURN_CYC  (TURN_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (host_req),
        .req_we     (host_we),
        .req_addr   (host_addr),
        .req_wdata  (host_wdata),
        .req_be     (host_be),
        .lane_cs_n  (lane_cs_n),
        .rd_masked  (rd_masked),
        .held_be    (held_be),
        .ready      (host_ready),
        .done       (host_done),
        .rdata      (host_rdata),
        .mem_addr   (mem_addr),
        .mem_cs_n   (mem_cs_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe)
    );

endmodule

// File: rtl/sram_lane_chk.sv
module sram_lane_chk #(
    parameter int ADDR_W    = 17,
    parameter int LANES     = 4,
    parameter int MIN_PULSE = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LANES-1:0]  mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe,
    input logic              host_done,
    input logic              host_ready
);

    // Length of the current write-enable-low run, counted in a register.
    logic [15:0] we_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        we_run_q <= '0;
        else if (mem_we_n) we_run_q <= '0;
        else               we_run_q <= we_run_q + 16'd1;
    end

    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);                                              // R8
    AST_WE_EXCLUDES_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);                                              // R8
    AST_WE_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);                                             // R4
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_n && we_run_q != 16'd0) |-> (we_run_q == 16'(MIN_PULSE)));   // R4
    AST_WE_FRAME_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> ($stable(mem_addr) && $stable(mem_cs_n)));              // R5
    AST_TURN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |=> (mem_cs_n == '1 && !mem_dq_oe));                  // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);                                            // R10
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> (mem_cs_n == '1 && mem_we_n && mem_oe_n));             // R11

endmodule

bind sram_lane_ctrl sram_lane_chk #(
    .ADDR_W    (ADDR_W),
    .LANES     (LANES),
    .MIN_PULSE (PULSE_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_oe  (mem_dq_oe),
    .host_done  (host_done),
    .host_ready (host_ready)
);

// File: tb/sim_sram_lane_ctrl.sv
module sim_sram_lane_ctrl;

    localparam int ADDR_W = 17;
    localparam int LANES  = 4;
    localparam int DW     = 32;
    localparam int PER    = 20;
    localparam int WC = 120, WP = 45, SCS = 15, AWN = 15, DS = 25;
    localparam int AA = 55, DOE = 8, HZ = 8;

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int EXP_PULSE = mx(1, mx(mx(cdiv(WP, PER), cdiv(DS, PER)), mx(cdiv(AWN, PER), cdiv(SCS, PER))));
    localparam int EXP_REC   = mx(1, cdiv(WC, PER) - 1 - EXP_PULSE);
    localparam int EXP_ACC   = mx(1, mx(cdiv(AA, PER), cdiv(DOE, PER)));
    localparam int EXP_TURN  = mx(1, cdiv(HZ, PER));

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_req = 1'b0;
    logic              host_we = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [DW-1:0]     host_wdata = '0;
    logic [LANES-1:0]  host_be = '0;
    logic              host_ready, host_done;
    logic [DW-1:0]     host_rdata;
    logic [ADDR_W-1:0] mem_addr;
    logic [LANES-1:0]  mem_cs_n;
    logic              mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0]     mem_dq_out;
    logic [DW-1:0]     mem_dq_in;

    always #10 clk = ~clk;

    sram_lane_ctrl #(
        .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(8), .CLK_PERIOD_NS(PER),
        .T_WC_NS(WC), .T_WP_NS(WP), .T_SCS_NS(SCS), .T_AW_NS(AWN), .T_DS_NS(DS),
        .T_AA_NS(AA), .T_DOE_NS(DOE), .T_HZ_NS(HZ)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
        .host_ready(host_ready), .host_done(host_done), .host_rdata(host_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    logic [DW-1:0]    model  [0:255];
    logic [DW-1:0]    shadow [0:255];
    logic [LANES-1:0] cur_be = '0;
    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] expand(input logic [LANES-1:0] m);
        logic [DW-1:0] r;
        for (int i = 0; i < LANES; i++) r[8*i +: 8] = {8{m[i]}};
        return r;
    endfunction

    // Device model: drives a byte only when its select and output enable are low and write enable is high.
    always_comb begin
        for (int i = 0; i < LANES; i++)
            mem_dq_in[8*i +: 8] = (!mem_cs_n[i] && mem_we_n && !mem_oe_n) ? model[mem_addr[7:0]][8*i +: 8] : 8'hA5;
    end

    // Strobe monitor, sampled away from the active edge.
    logic [LANES-1:0]  prev_cs_n = '1;
    logic              prev_we_n = 1'b1;
    logic [ADDR_W-1:0] prev_addr = '0;
    logic [DW-1:0]     prev_dq = '0;
    int we_run = 0, cs_run = 0, oe_run = 0, gap = 0;
    bit run_wrote = 0, last_read = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe) chk(mem_oe_n, "R8 drive with oe low", {31'd0, mem_oe_n}, 32'd1);
            if (!mem_we_n) chk(mem_oe_n, "R8 we low with oe low", {31'd0, mem_oe_n}, 32'd1);
            for (int i = 0; i < LANES; i++)
                if (!prev_cs_n[i] && !prev_we_n && (mem_cs_n[i] || mem_we_n))
                    model[prev_addr[7:0]][8*i +: 8] = prev_dq[8*i +: 8];
            if (!prev_we_n)
                chk(mem_addr == prev_addr && mem_cs_n == prev_cs_n && mem_dq_out == prev_dq,
                    "R5 frame moved", {15'd0, mem_addr}, {15'd0, prev_addr});
            if (!mem_we_n) begin
                we_run++;
                chk(mem_dq_oe, "R4 data not driven", {31'd0, mem_dq_oe}, 32'd1);
            end else if (we_run != 0) begin
                chk(we_run == EXP_PULSE, "R4 pulse width", we_run, EXP_PULSE);
                if (cur_be != 0) chk(cs_run == 1 + EXP_PULSE, "R4 setup+pulse", cs_run, 1 + EXP_PULSE);
                we_run = 0;
            end
            if (mem_cs_n != '1) begin
                if (cs_run == 0) begin
                    chk(mem_cs_n == ~cur_be, "R2 select pattern", {28'd0, mem_cs_n}, {28'd0, ~cur_be});
                    if (last_read) chk(gap >= EXP_TURN + 1, "R9 turnaround", gap, EXP_TURN + 1);
                    oe_run = 0;
                end
                cs_run++;
                if (!mem_we_n) run_wrote = 1;
                if (!mem_oe_n) oe_run++;
            end else if (cs_run != 0) begin
                if (run_wrote)
                    chk(cs_run == 1 + EXP_PULSE + EXP_REC && cs_run >= cdiv(WC, PER),
                        "R12 write cycle", cs_run, 1 + EXP_PULSE + EXP_REC);
                else
                    chk(oe_run == EXP_ACC, "R6 access phase", oe_run, EXP_ACC);
                last_read = !run_wrote;
                run_wrote = 0;
                cs_run = 0;
                gap = 1;
            end else begin
                gap++;
            end
            prev_cs_n = mem_cs_n;
            prev_we_n = mem_we_n;
            prev_addr = mem_addr;
            prev_dq   = mem_dq_out;
        end
    end

    task automatic access(input bit we, input logic [ADDR_W-1:0] a, input logic [DW-1:0] wd,
                          input logic [LANES-1:0] be, output logic [DW-1:0] rd);
        int lat;
        int exp_lat;
        while (!host_ready) @(negedge clk);
        cur_be     = be;
        host_req   = 1'b1;
        host_we    = we;
        host_addr  = a;
        host_wdata = wd;
        host_be    = be;
        @(negedge clk);
        host_req = 1'b0;
        lat = 1;
        chk(!host_ready, "R11 ready while busy", {31'd0, host_ready}, 32'd0);
        while (!host_done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        exp_lat = we ? (2 + EXP_PULSE + EXP_REC) : (1 + EXP_ACC + EXP_TURN);
        chk(lat == exp_lat, "R10 done latency", lat, exp_lat);
        chk(host_ready, "R11 ready with done", {31'd0, host_ready}, 32'd1);
        rd = host_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        for (int i = 0; i < 256; i++) begin
            model[i]  = '0;
            shadow[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(mem_cs_n == '1 && mem_we_n && mem_oe_n && !mem_dq_oe && !host_done && host_ready,
            "R1 reset state", {26'd0, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, host_done},
            {26'd0, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0});
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 16; a++) begin
            logic [ADDR_W-1:0] adr;
            logic [DW-1:0]     base;
            adr  = ADDR_W'(a * 8209);
            base = (32'h1000_0001 * (a + 1)) ^ 32'hC3A5_5A3C;
            access(1'b1, adr, base, 4'hF, rd);
            shadow[adr[7:0]] = base;
            access(1'b0, adr, '0, 4'hF, rd);
            chk(rd == base, "R3 full read-back", rd, base);
            for (int m = 0; m < 16; m++) begin
                logic [DW-1:0] wd;
                wd = ~base ^ (32'h0101_0101 * m) ^ (32'h0F1E_2D3C * a);
                access(1'b1, adr, wd, 4'(m), rd);
                shadow[adr[7:0]] = (shadow[adr[7:0]] & ~expand(4'(m))) | (wd & expand(4'(m)));
                for (int r = 0; r < 16; r++) begin
                    logic [DW-1:0] ex;
                    access(1'b0, adr, '0, 4'(r), rd);
                    ex = shadow[adr[7:0]] & expand(4'(r));
                    if (r == 15) chk(rd == ex, "R3 masked write", rd, ex);
                    else         chk(rd == ex, "R7 masked read", rd, ex);
                end
            end
        end
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule